// File: doc/BRIEF.md
# Raster Line and Field Timing Generator

This block produces every line and field timing signal for a 625-line, 50 Hz style interlace-free raster from one 4 MHz clock. A cascade of synchronous modulo counters divides the clock into a 2 MHz tick, 4 µs columns, 64 µs lines, 26-line groups and a 12-group field of 312 lines, or about 20 ms. The outputs are decoded from the counter states.

Downstream pattern and encoder logic uses the sync and blanking outputs, and the composite forms of both. It builds test images from the grid strobes and the two checkerboard square waves. Every output is a single active-high bit. Every output changes only on the clock edge that moves the counters.

Top module: `raster_timing_gen`

## Requirements
- R1: The counters advance once every 2 master clocks. `vline_o` is high for exactly one master clock out of every 16: the first clock of each 4 µs column.
- R2: A line lasts 256 master clocks. `hsync_o` is high for the first 16 clocks of each line (4 µs).
- R3: `hblank_o` is high for the first 40 clocks of each line (10 µs). It is built as an 8 µs pulse stretched by 2 µs, and it is high whenever `hsync_o` is high.
- R4: Within a line, `hchk_o` is high for clocks 0–31 of each 64-clock span and low for clocks 32–63. This gives 8 µs high and 8 µs low.
- R5: Lines are counted modulo 26. `hline_o` is high for the whole of line 0 of each group and low on lines 1–25.
- R6: A field lasts 12 groups, which is 312 lines or 79872 clocks. `vblank_o` is high for lines 0–25 of the field. After a field wraps, the next clock shows line 0 with `vblank_o` and `hsync_o` high.
- R7: `vsync_o` is high for lines 4–7 of the field. It starts 256 µs after blanking starts and ends after 512 µs, and it is high only while `vblank_o` is high.
- R8: `vchk_o` changes every second group. It is low for groups 0–1, high for groups 2–3, and so on.
- R9: `csync_o` equals `hsync_o | vsync_o`, and `cblank_o` equals `hblank_o | vblank_o`, in every cycle.
- R10: While `rst_ni` is low, the raster sits at line 0, tick 0. `vline_o`, `hsync_o`, `hblank_o`, `hline_o`, `vblank_o`, `hchk_o`, `csync_o` and `cblank_o` are high; `vsync_o` and `vchk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4 MHz master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vline_o | output | 1 | Vertical grid line strobe |
| hline_o | output | 1 | Horizontal grid line strobe |
| hsync_o | output | 1 | Horizontal sync |
| hblank_o | output | 1 | Horizontal blanking |
| vsync_o | output | 1 | Vertical sync |
| vblank_o | output | 1 | Vertical blanking |
| csync_o | output | 1 | Composite sync |
| cblank_o | output | 1 | Composite blanking |
| hchk_o | output | 1 | Horizontal checkerboard square wave |
| vchk_o | output | 1 | Vertical checkerboard square wave |

## Verification
The bench uses the default parameters: divide by 2, 8 ticks per column, 16 columns, 26 lines per group and 12 groups. At these values one full field is 79872 clocks, so the bench sweeps every clock of a complete field and into the next. It compares all ten outputs against values derived arithmetically from the clock index. This reaches every column edge, every line and group boundary, the vertical sync window and the field wrap. A second reset applied in mid-field confirms the return to the line 0 state and a clean restart.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned NSTAGE = 5;

  typedef enum int unsigned {
    STG_PRE  = 0,
    STG_TICK = 1,
    STG_COL  = 2,
    STG_LINE = 3,
    STG_GRP  = 4
  } stage_e;

  function automatic int unsigned width_for(input int unsigned maxval);
    int unsigned w;
    w = 1;
    while ((1 << w) <= maxval) w++;
    return w;
  endfunction
endpackage

// File: rtl/raster_div_stage.sv
module raster_div_stage #(
  parameter int unsigned MOD = 2,
  parameter int unsigned W   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= wrap_o ? '0 : cnt_q + W'(1);
  end

  assert_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_hold_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/raster_hdecode.sv
module raster_hdecode #(
  parameter int unsigned W            = 8,
  parameter int unsigned HSYNC_COLS   = 1,
  parameter int unsigned HB_BASE_COLS = 2,
  parameter int unsigned HB_EXT_TICKS = 4,
  parameter int unsigned CHK_COLS     = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pre_i,
  input  logic [W-1:0] tick_i,
  input  logic [W-1:0] col_i,
  output logic         vline_o,
  output logic         hsync_o,
  output logic         hblank_o,
  output logic         hchk_o
);
  localparam logic [W-1:0] SYNC_END = W'(HSYNC_COLS);
  localparam logic [W-1:0] HB_COL   = W'(HB_BASE_COLS);
  localparam logic [W-1:0] HB_EXT   = W'(HB_EXT_TICKS);
  localparam logic [W-1:0] CHK_DIV  = W'(CHK_COLS);

  logic base_pulse, ext_pulse;
  logic [W-1:0] chk_idx;

  assign vline_o    = (pre_i == '0) && (tick_i == '0);
  assign hsync_o    = (col_i < SYNC_END);
  // 8 us base pulse, stretched by the first ticks of the following column
  assign base_pulse = (col_i < HB_COL);
  assign ext_pulse  = (col_i == HB_COL) && (tick_i < HB_EXT);
  assign hblank_o   = base_pulse || ext_pulse;
  assign chk_idx    = col_i / CHK_DIV;
  assign hchk_o     = ~chk_idx[0];

  assert_sync_in_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> hblank_o);
  assert_strobe_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vline_o |=> !vline_o);
endmodule

// File: rtl/raster_vdecode.sv
module raster_vdecode #(
  parameter int unsigned W           = 8,
  parameter int unsigned VS_START    = 4,
  parameter int unsigned VS_LINES    = 4,
  parameter int unsigned CHK_GROUPS  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] grp_i,
  output logic         hline_o,
  output logic         vblank_o,
  output logic         vsync_o,
  output logic         vchk_o
);
  localparam logic [W-1:0] VS_FIRST = W'(VS_START);
  localparam logic [W-1:0] VS_END   = W'(VS_START + VS_LINES);
  localparam logic [W-1:0] CHK_DIV  = W'(CHK_GROUPS);

  logic [W-1:0] chk_idx;

  assign hline_o  = (line_i == '0);
  assign vblank_o = (grp_i == '0);
  assign vsync_o  = vblank_o && (line_i >= VS_FIRST) && (line_i < VS_END);
  assign chk_idx  = grp_i / CHK_DIV;
  assign vchk_o   = chk_idx[0];

  assert_vsync_in_vblank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> vblank_o);
  assert_vsync_not_first_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> !hline_o);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned CLK_DIV        = 2,
  parameter int unsigned TICKS_PER_COL  = 8,
  parameter int unsigned COLS_PER_LINE  = 16,
  parameter int unsigned LINES_PER_GRP  = 26,
  parameter int unsigned GRPS_PER_FIELD = 12,
  parameter int unsigned HSYNC_COLS     = 1,
  parameter int unsigned HB_BASE_COLS   = 2,
  parameter int unsigned HB_EXT_TICKS   = 4,
  parameter int unsigned CHK_COLS       = 2,
  parameter int unsigned VS_START       = 4,
  parameter int unsigned VS_LINES       = 4,
  parameter int unsigned CHK_GROUPS     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic vline_o,
  output logic hline_o,
  output logic hsync_o,
  output logic hblank_o,
  output logic vsync_o,
  output logic vblank_o,
  output logic csync_o,
  output logic cblank_o,
  output logic hchk_o,
  output logic vchk_o
);
  localparam int unsigned MODS [NSTAGE] =
    '{CLK_DIV, TICKS_PER_COL, COLS_PER_LINE, LINES_PER_GRP, GRPS_PER_FIELD};
  localparam int unsigned MAXMOD = (COLS_PER_LINE > LINES_PER_GRP) ? COLS_PER_LINE : LINES_PER_GRP;
  localparam int unsigned MAXALL = (MAXMOD > GRPS_PER_FIELD) ? MAXMOD : GRPS_PER_FIELD;
  localparam int unsigned CW     = width_for(MAXALL > TICKS_PER_COL ? MAXALL : TICKS_PER_COL);

  logic [CW-1:0]     cnt  [NSTAGE];
  logic [NSTAGE-1:0] en;
  logic [NSTAGE-1:0] wrap;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign en[i] = 1'b1;
    end else begin : g_next
      assign en[i] = en[i-1] & wrap[i-1];
    end
    raster_div_stage #(.MOD(MODS[i]), .W(CW)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[i]),
      .cnt_o  (cnt[i]),
      .wrap_o (wrap[i])
    );
  end

  raster_hdecode #(
    .W(CW), .HSYNC_COLS(HSYNC_COLS), .HB_BASE_COLS(HB_BASE_COLS),
    .HB_EXT_TICKS(HB_EXT_TICKS), .CHK_COLS(CHK_COLS)
  ) u_hdec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pre_i    (cnt[STG_PRE]),
    .tick_i   (cnt[STG_TICK]),
    .col_i    (cnt[STG_COL]),
    .vline_o  (vline_o),
    .hsync_o  (hsync_o),
    .hblank_o (hblank_o),
    .hchk_o   (hchk_o)
  );

  raster_vdecode #(
    .W(CW), .VS_START(VS_START), .VS_LINES(VS_LINES), .CHK_GROUPS(CHK_GROUPS)
  ) u_vdec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (cnt[STG_LINE]),
    .grp_i    (cnt[STG_GRP]),
    .hline_o  (hline_o),
    .vblank_o (vblank_o),
    .vsync_o  (vsync_o),
    .vchk_o   (vchk_o)
  );

  assign csync_o  = hsync_o | vsync_o;
  assign cblank_o = hblank_o | vblank_o;

  assert_field_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en[STG_GRP] && wrap[STG_GRP]) |=> (vblank_o && hsync_o && hline_o && vline_o));
  assert_vblank_starts_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vblank_o) |-> hsync_o);
  assert_cblank_covers_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vblank_o || hblank_o) |-> cblank_o);
  assert_csync_covers_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_o || hsync_o) |-> csync_o);
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int LINE_CLK  = 256;
  localparam int GRP_LINES = 26;
  localparam int FLD_LINES = 312;
  localparam int FLD_CLK   = LINE_CLK * FLD_LINES;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vline, hline, hsync, hblank, vsync, vblank, csync, cblank, hchk, vchk;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  raster_timing_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .vline_o(vline), .hline_o(hline), .hsync_o(hsync), .hblank_o(hblank),
    .vsync_o(vsync), .vblank_o(vblank), .csync_o(csync), .cblank_o(cblank),
    .hchk_o(hchk), .vchk_o(vchk)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what, input int c);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      if (n_err <= 30)
        $display("FAIL %s %s at clock %0d: actual=%0b expected=%0b", req, what, c, act, exp);
    end
  endtask

  task automatic check_at(input int c);
    int fc, lc, col, line, grp;
    bit e_hs, e_hb, e_vs, e_vb;
    fc   = c % FLD_CLK;
    lc   = fc % LINE_CLK;
    col  = lc / 16;
    line = (fc / LINE_CLK) % GRP_LINES;
    grp  = fc / (LINE_CLK * GRP_LINES);
    e_hs = (lc < 16);
    e_hb = (lc < 40);
    e_vb = (grp == 0);
    e_vs = e_vb && (line >= 4) && (line < 8);
    chk(vline,  (lc % 16) == 0,          "R1", "vline",  c);
    chk(hsync,  e_hs,                    "R2", "hsync",  c);
    chk(hblank, e_hb,                    "R3", "hblank", c);
    chk(hchk,   ((col / 2) % 2) == 0,    "R4", "hchk",   c);
    chk(hline,  line == 0,               "R5", "hline",  c);
    chk(vblank, e_vb,                    "R6", "vblank", c);
    chk(vsync,  e_vs,                    "R7", "vsync",  c);
    chk(vchk,   ((grp / 2) % 2) == 1,    "R8", "vchk",   c);
    chk(csync,  e_hs | e_vs,             "R9", "csync",  c);
    chk(cblank, e_hb | e_vb,             "R9", "cblank", c);
  endtask

  task automatic check_reset();
    chk(vline,  1'b1, "R10", "reset vline",  -1);
    chk(hsync,  1'b1, "R10", "reset hsync",  -1);
    chk(hblank, 1'b1, "R10", "reset hblank", -1);
    chk(hline,  1'b1, "R10", "reset hline",  -1);
    chk(vblank, 1'b1, "R10", "reset vblank", -1);
    chk(hchk,   1'b1, "R10", "reset hchk",   -1);
    chk(csync,  1'b1, "R10", "reset csync",  -1);
    chk(cblank, 1'b1, "R10", "reset cblank", -1);
    chk(vsync,  1'b0, "R10", "reset vsync",  -1);
    chk(vchk,   1'b0, "R10", "reset vchk",   -1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check_reset();
    rst_ni = 1'b1;
    // full field plus the wrap into the next one (R1..R9, R6 field wrap)
    for (int c = 0; c < FLD_CLK + 3000; c++) begin
      check_at(c);
      @(negedge clk);
    end
    // mid-field reset (R10) then clean restart
    rst_ni = 1'b0;
    @(negedge clk);
    check_reset();
    @(negedge clk);
    check_reset();
    rst_ni = 1'b1;
    for (int c = 0; c < 3 * LINE_CLK; c++) begin
      check_at(c);
      @(negedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule